// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

This block is a memory-mapped mailbox that carries whole network packets between a host and a link, one byte per register access. A received packet arrives on a byte-stream ingress (valid, ready, last) and is stored in an internal receive buffer. The host learns its length from a receive count register. It then reads the packet one byte at a time from a data port, and each read lowers the count. To send, the host programs a transmit byte count and writes that many bytes to a transmit data port. The block then streams the packet out on a byte-stream egress.

A single interrupt output reports three sources: transmit accepted, receive complete, and a host-triggered self-test condition. The completion bits are cleared by writing one. While the receive-complete bit is set, ingress is stalled, so only one received packet is held at a time. The host uses a synchronous register bus. Reads return data on the cycle after the read strobe.

Top module: `pkt_mailbox`

## Requirements
- R1: Offset 0x00 reads 0x4D544B50 and offset 0x04 reads 0x31584F42. Together these form the ASCII string "PKTMBOX1", with the first character in the low byte of 0x00 and the final version digit '1' in the top byte of 0x04.
- R2: Offset 0x08 reads 1 in bit 0 while an ingress packet is partly received or an egress packet is still draining, and 0 otherwise. Writes to 0x08 have no effect.
- R3: When the ingress beat with last is accepted, the receive count at 0x0C is loaded with the packet length in bytes, and interrupt-control bit 1 (receive done) is set.
- R4: Each read of offset 0x1C returns the next received byte in bits 7:0 and lowers the receive count by one. A read made when the count is 0 returns 0 and changes nothing.
- R5: An ingress packet longer than the buffer depth (256 bytes by default) keeps only its first depth bytes, and the count reports the depth.
- R6: While interrupt-control bit 1 is set, in_ready is low.
- R7: The host writes a count to 0x10 and then bytes to 0x20, of which only bits 7:0 are used. On the write of the final byte, 0x10 reads 0 and interrupt-control bit 0 (transmit done) sets. Data writes beyond the programmed count are ignored.
- R8: Writing 1 to bit 0 or bit 1 of offset 0x14 clears that bit. Writing 0 to either bit leaves it unchanged.
- R9: Egress presents the transmitted bytes in write order. It asserts out_last on the final byte and holds out_data and out_last stable while out_valid is high and out_ready is low.
- R10: Writing a value with bit 31 set to 0x14 raises a test condition. The next read of 0x14 shows bit 31 as 1, and the read after that shows 0. Writing 0x00000000 to 0x14 removes the test condition.
- R11: irq is high exactly when transmit done, receive done or the test condition is set. The test condition keeps irq high after bit 31 has read-cleared.
- R12: Offset 0x18 reads the parameter IRQ_INFO (default 3).
- R13: After reset, irq and out_valid are low, in_ready is high, and offsets 0x08, 0x0C, 0x10 and 0x14 all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Final ingress byte of a packet |
| in_ready | output | 1 | Ingress accepts a byte |
| out_valid | output | 1 | Egress byte valid |
| out_data | output | 8 | Egress byte |
| out_last | output | 1 | Final egress byte of a packet |
| out_ready | input | 1 | Egress sink accepts a byte |
| irq | output | 1 | Interrupt request |

## Verification
The final transmit data write and the last ingress beat can both land on one clock edge. In that case transmit done and receive done set in the same cycle. The bench provokes this by driving the final tx data-port write and the in_last beat at the same clock edge. It then checks that interrupt control reads both bits set and that irq is high. Clearing bit 0 alone must leave bit 1 set and irq high. Clearing bit 1 afterwards must drop irq. The bench also checks that the egress stream and the receive data are both intact after the overlap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned AW = 6;
  localparam logic [AW-1:0] OFS_ID_LO = 6'h00;
  localparam logic [AW-1:0] OFS_ID_HI = 6'h04;
  localparam logic [AW-1:0] OFS_BUSY  = 6'h08;
  localparam logic [AW-1:0] OFS_RXCNT = 6'h0C;
  localparam logic [AW-1:0] OFS_TXCNT = 6'h10;
  localparam logic [AW-1:0] OFS_CTL   = 6'h14;
  localparam logic [AW-1:0] OFS_INFO  = 6'h18;
  localparam logic [AW-1:0] OFS_RXD   = 6'h1C;
  localparam logic [AW-1:0] OFS_TXD   = 6'h20;
  // "PKTMBOX1", first character in the lowest byte
  localparam logic [63:0] DEV_ID = 64'h3158_4F42_4D54_4B50;
  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_SEND} tx_state_t;
endpackage

// File: rtl/mbx_rx_buf.sv
module mbx_rx_buf #(
  parameter int unsigned BUF_AW = 8,
  localparam int unsigned CW = BUF_AW + 1,
  localparam int unsigned DEPTH = 1 << BUF_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          rx_block,
  input  logic          rd_pop,
  output logic [CW-1:0] rx_cnt,
  output logic [7:0]    rx_byte,
  output logic          rx_set,
  output logic          filling
);
  logic [7:0]        mem [DEPTH];
  logic [7:0]        mem_q;
  logic              zero_q;
  logic [CW-1:0]     wr_cnt;
  logic [BUF_AW-1:0] rd_ptr;
  logic              accept, room;

  assign in_ready = ~rx_block;
  assign accept   = in_valid & in_ready;
  assign room     = wr_cnt < CW'(DEPTH);
  assign rx_set   = accept & in_last;
  assign rx_byte  = zero_q ? 8'h00 : mem_q;

  always_ff @(posedge clk) begin
    if (accept && room) mem[wr_cnt[BUF_AW-1:0]] <= in_data;
    if (rd_pop) mem_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt  <= '0;
      rd_ptr  <= '0;
      rx_cnt  <= '0;
      zero_q  <= 1'b1;
      filling <= 1'b0;
    end else begin
      if (rd_pop) zero_q <= (rx_cnt == '0);
      if (accept && in_last) begin
        rx_cnt  <= wr_cnt + CW'(room);
        wr_cnt  <= '0;
        rd_ptr  <= '0;
        filling <= 1'b0;
      end else begin
        if (accept) begin
          wr_cnt  <= wr_cnt + CW'(room);
          filling <= 1'b1;
        end
        if (rd_pop && rx_cnt != '0) begin
          rx_cnt <= rx_cnt - 1'b1;
          rd_ptr <= rd_ptr + 1'b1;
        end
      end
    end
  end

  a_r4_pop_decrements: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && rx_cnt != '0 && !accept) |=> rx_cnt == $past(rx_cnt) - 1'b1);
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));
endmodule

// File: rtl/mbx_tx_buf.sv
module mbx_tx_buf
  import mbx_pkg::*;
#(
  parameter int unsigned BUF_AW = 8,
  localparam int unsigned CW = BUF_AW + 1,
  localparam int unsigned DEPTH = 1 << BUF_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_we,
  input  logic          data_we,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] tx_cnt,
  output logic          tx_set,
  output logic          draining,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          out_last
);
  logic [7:0]    mem [DEPTH];
  logic [7:0]    mem_q;
  logic [CW-1:0] wr_ptr, rd_ptr, len;
  tx_state_t     st;
  logic          take;

  assign draining = (st != TX_IDLE);
  assign take     = data_we && !draining && (wr_ptr < tx_cnt);
  assign tx_set   = take && ((wr_ptr + CW'(1)) == tx_cnt);
  assign out_data = mem_q;

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr[BUF_AW-1:0]] <= wdata[7:0];
    if (st == TX_FETCH) mem_q <= mem[rd_ptr[BUF_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      tx_cnt    <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      len       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE: begin
          if (cnt_we) begin
            tx_cnt <= (wdata > 32'(DEPTH)) ? CW'(DEPTH) : wdata[CW-1:0];
            wr_ptr <= '0;
          end else if (take) begin
            if (tx_set) begin
              tx_cnt <= '0;
              len    <= tx_cnt;
              wr_ptr <= '0;
              rd_ptr <= '0;
              st     <= TX_FETCH;
            end else begin
              wr_ptr <= wr_ptr + 1'b1;
            end
          end
        end
        TX_FETCH: begin
          out_valid <= 1'b1;
          out_last  <= (rd_ptr == len - 1'b1);
          rd_ptr    <= rd_ptr + 1'b1;
          st        <= TX_SEND;
        end
        default: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            st        <= out_last ? TX_IDLE : TX_FETCH;
          end
        end
      endcase
    end
  end

  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  a_r9_last_ends_packet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic        ctl_re,
  input  logic [31:0] wdata,
  input  logic        tx_set,
  input  logic        rx_set,
  output logic        tx_done,
  output logic        rx_done,
  output logic        test_view,
  output logic        irq
);
  logic test_pend;

  assign irq = tx_done | rx_done | test_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done   <= 1'b0;
      rx_done   <= 1'b0;
      test_view <= 1'b0;
      test_pend <= 1'b0;
    end else begin
      if (tx_set) tx_done <= 1'b1;
      else if (ctl_we && wdata[0]) tx_done <= 1'b0;
      if (rx_set) rx_done <= 1'b1;
      else if (ctl_we && wdata[1]) rx_done <= 1'b0;
      if (ctl_we) begin
        if (wdata == 32'h0) begin
          test_view <= 1'b0;
          test_pend <= 1'b0;
        end else if (wdata[31]) begin
          test_view <= 1'b1;
          test_pend <= 1'b1;
        end
      end else if (ctl_re) begin
        test_view <= 1'b0;
      end
    end
  end

  a_r8_w1c_tx: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[0] && !tx_set) |=> !tx_done);
  a_r8_w1c_rx: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[1] && !rx_set) |=> !rx_done);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_re && !ctl_we && test_view) |=> !test_view);
  a_r11_test_keeps_irq: assert property (@(posedge clk) disable iff (rst)
    (ctl_re && !ctl_we && test_view) |=> irq);
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned BUF_AW   = 8,
  parameter logic [31:0] IRQ_INFO = 32'd3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        irq
);
  localparam int unsigned CW = BUF_AW + 1;

  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_byte;
  logic          rx_set, tx_set, filling, draining;
  logic          tx_done, rx_done, test_view;
  logic [31:0]   rdata_q, rd_mux;
  logic          rxd_sel_q;
  logic          busy_q;

  mbx_rx_buf #(.BUF_AW(BUF_AW)) u_rx (
    .clk, .rst, .in_valid, .in_data, .in_last, .in_ready,
    .rx_block(rx_done),
    .rd_pop(bus_rd && bus_addr == OFS_RXD),
    .rx_cnt, .rx_byte, .rx_set, .filling
  );

  mbx_tx_buf #(.BUF_AW(BUF_AW)) u_tx (
    .clk, .rst,
    .cnt_we(bus_wr && bus_addr == OFS_TXCNT),
    .data_we(bus_wr && bus_addr == OFS_TXD),
    .wdata(bus_wdata),
    .tx_cnt, .tx_set, .draining,
    .out_valid, .out_data, .out_ready, .out_last
  );

  mbx_irq u_irq (
    .clk, .rst,
    .ctl_we(bus_wr && bus_addr == OFS_CTL),
    .ctl_re(bus_rd && bus_addr == OFS_CTL),
    .wdata(bus_wdata),
    .tx_set, .rx_set, .tx_done, .rx_done, .test_view, .irq
  );

  always_comb begin
    rd_mux = 32'h0;
    unique case (bus_addr)
      OFS_ID_LO: rd_mux = DEV_ID[31:0];
      OFS_ID_HI: rd_mux = DEV_ID[63:32];
      OFS_BUSY:  rd_mux = {31'h0, busy_q};
      OFS_RXCNT: rd_mux = 32'(rx_cnt);
      OFS_TXCNT: rd_mux = 32'(tx_cnt);
      OFS_CTL:   rd_mux = {test_view, 29'h0, rx_done, tx_done};
      OFS_INFO:  rd_mux = IRQ_INFO;
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      rxd_sel_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= filling | draining;
      if (bus_rd) begin
        rdata_q   <= rd_mux;
        rxd_sel_q <= (bus_addr == OFS_RXD);
      end
    end
  end

  assign bus_rdata = rxd_sel_q ? {24'h0, rx_byte} : rdata_q;

  a_r6_rx_blocks_ingress: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> !in_ready);
  a_r11_sources_raise_irq: assert property (@(posedge clk) disable iff (rst)
    (tx_done || rx_done) |-> irq);
  a_r3_last_sets_done: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> (rx_done && rx_cnt != '0));
  a_r7_final_write_clears_count: assert property (@(posedge clk) disable iff (rst)
    tx_set |=> (tx_cnt == '0 && tx_done));
endmodule

// File: tb/pkt_mailbox_tb.sv
module pkt_mailbox_tb;
  localparam int DEPTH = 256;

  logic        clk = 0, rst = 1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        in_valid = 0, in_last = 0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_last, out_ready = 0, irq;
  logic [7:0]  out_data;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [8:0] egq [$];
  logic [7:0] rxq [$];
  logic [2:0] rdy_ctr = '0;

  pkt_mailbox u_dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    rdy_ctr   <= rdy_ctr + 1'b1;
    out_ready <= (rdy_ctr[1:0] != 2'b01);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // egress monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (egq.size() == 0) check("R9 unexpected egress byte", {23'h0, out_last, out_data}, 32'h1FF);
      else begin
        logic [8:0] e;
        e = egq.pop_front();
        check("R9 egress byte/last", {23'h0, out_last, out_data}, {23'h0, e});
      end
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      if (i < DEPTH) rxq.push_back(pat(seed, i));
      in_valid = 1; in_data = pat(seed, i); in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic rx_drain(input int n, input string req);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(6'h1C, d);
      check(req, d, {24'h0, rxq.pop_front()});
    end
  endtask

  task automatic wait_egress;
    for (int k = 0; k < 2000 && egq.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9 egress queue drained", egq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    check("R13 irq", irq, 0);
    check("R13 in_ready", in_ready, 1);
    check("R13 out_valid", out_valid, 0);
    rd(6'h08, d); check("R13 busy", d, 0);
    rd(6'h0C, d); check("R13 rx count", d, 0);
    rd(6'h10, d); check("R13 tx count", d, 0);
    rd(6'h14, d); check("R13 ctl", d, 0);
    // R1 / R12
    rd(6'h00, d); check("R1 id low", d, 32'h4D544B50);
    rd(6'h04, d); check("R1 id high", d, 32'h31584F42);
    rd(6'h18, d); check("R12 info", d, 32'd3);
    // R2 write to busy ignored
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, d); check("R2 busy write ignored", d, 0);

    // R10 / R11 test interrupt
    wr(6'h14, 32'h8000_0000);
    check("R10 test raises irq", irq, 1);
    rd(6'h14, d); check("R10 bit31 first read", d, 32'h8000_0000);
    rd(6'h14, d); check("R10 bit31 read-cleared", d, 0);
    check("R11 irq held by test condition", irq, 1);
    wr(6'h14, 32'h0);
    check("R10 write zero drops irq", irq, 0);

    // R2 / R3 busy during partial ingress
    for (int i = 0; i < 2; i++) begin
      rxq.push_back(pat(8'h10, i));
      @(negedge clk); in_valid = 1; in_data = pat(8'h10, i); in_last = 0;
    end
    @(negedge clk); in_valid = 0;
    rd(6'h08, d); check("R2 busy during ingress", d, 1);
    rxq.push_back(pat(8'h10, 2));
    in_valid = 1; in_data = pat(8'h10, 2); in_last = 1;
    @(negedge clk); in_valid = 0; in_last = 0;
    @(negedge clk);
    check("R6 ready low while rx done", in_ready, 0);
    check("R11 rx done raises irq", irq, 1);
    rd(6'h0C, d); check("R3 rx count", d, 3);
    rd(6'h14, d); check("R3 rx done bit", d, 32'h2);
    rd(6'h08, d); check("R2 busy idle after ingress", d, 0);
    // R6 offered byte not taken while blocked
    in_valid = 1; in_data = 8'hEE; in_last = 1;
    repeat (4) @(negedge clk);
    in_valid = 0; in_last = 0;
    rd(6'h0C, d); check("R6 count unchanged while blocked", d, 3);
    rx_drain(3, "R4 rx byte");
    rd(6'h0C, d); check("R4 count reaches zero", d, 0);
    rd(6'h1C, d); check("R4 empty read returns zero", d, 0);
    rd(6'h0C, d); check("R4 empty read leaves count", d, 0);
    wr(6'h14, 32'h0);
    rd(6'h14, d); check("R8 write zero keeps rx bit", d, 32'h2);
    wr(6'h14, 32'h2);
    rd(6'h14, d); check("R8 w1c rx bit", d, 0);
    check("R8 irq low after clear", irq, 0);
    check("R6 ready back high", in_ready, 1);

    // R5 truncation
    send_pkt(DEPTH + 4, 8'h33);
    rd(6'h0C, d); check("R5 truncated count", d, DEPTH);
    rx_drain(DEPTH, "R5 kept byte");
    wr(6'h14, 32'h2);

    // R7 / R9 transmit
    wr(6'h10, 32'd6);
    rd(6'h10, d); check("R7 tx count programmed", d, 6);
    for (int i = 0; i < 6; i++) begin
      egq.push_back({(i == 5), pat(8'h80, i)});
      wr(6'h20, {24'hABCDEF, pat(8'h80, i)});
    end
    rd(6'h08, d); check("R2 busy during drain", d, 1);
    wr(6'h20, 32'h55); wr(6'h20, 32'h66);
    rd(6'h10, d); check("R7 count cleared", d, 0);
    rd(6'h14, d); check("R7 tx done bit", d, 32'h1);
    wait_egress();
    wr(6'h14, 32'h1);
    check("R8 w1c tx drops irq", irq, 0);

    // collision: final tx write and ingress last in one cycle
    wr(6'h10, 32'd3);
    for (int i = 0; i < 2; i++) begin
      egq.push_back({1'b0, pat(8'h40, i)});
      wr(6'h20, {24'h0, pat(8'h40, i)});
    end
    for (int i = 0; i < 3; i++) begin
      rxq.push_back(pat(8'h20, i));
      @(negedge clk); in_valid = 1; in_data = pat(8'h20, i); in_last = 0;
    end
    egq.push_back({1'b1, pat(8'h40, 2)});
    rxq.push_back(pat(8'h20, 3));
    @(negedge clk);
    in_valid = 1; in_data = pat(8'h20, 3); in_last = 1;
    bus_addr = 6'h20; bus_wdata = {24'h0, pat(8'h40, 2)}; bus_wr = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0; bus_wr = 0;
    rd(6'h14, d); check("R3 R7 both done bits", d, 32'h3);
    check("R11 irq both sources", irq, 1);
    wr(6'h14, 32'h1);
    rd(6'h14, d); check("R8 only tx cleared", d, 32'h2);
    check("R11 irq from rx alone", irq, 1);
    rd(6'h0C, d); check("R3 collision rx count", d, 4);
    rx_drain(4, "R4 collision rx byte");
    wait_egress();
    wr(6'h14, 32'h2);
    check("R11 irq low after both cleared", irq, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule